// File: doc/BRIEF.md
# Two-Stage Watchdog with Reset Request

This block is a byte-addressed watchdog for a power-management controller. Once armed, it counts seconds from a one-per-second tick input. The count runs in two stages, one after the other. When the first stage runs out, the block raises a bark: a status bit and a level interrupt that warn software a reset is near. If software does not kick the watchdog, the second stage keeps counting. When the second stage runs out, the block issues a one-cycle reset request that carries a programmable reset-type code.

Software uses a simple register port to program the two stage lengths, the reset type and the arm bit, and to write the kick. The block also holds sticky power-off cause flags: one for a watchdog-caused reset, one for undervoltage and one for over-temperature. The undervoltage and over-temperature events arrive as input pulses. These flags are cleared only by a separate power-on reset, so boot software can still read them after the reset that this block itself requested.

Top module: `wdog_two_stage`

## Requirements
- R1: After the block reset, the stage-1 time (offset 0x54) reads 32, the stage-2 time (0x55) reads 0, the reset type (0x56) reads 0x07, the arm register (0x57) reads 0, `irq` is low and `rst_req` is 0.
- R2: The timer registers keep the low 7 bits of a write. A read of offset 0x58 or of any unmapped offset returns 0.
- R3: Writing bit 7 of 0x57 as 1 while disarmed starts stage 1, and 0x57 then reads 0x80. Writing it as 1 while already armed does not restart the count. Writing it as 0 disarms the watchdog and clears the bark; while disarmed, ticks cause no bark and no reset request.
- R4: With a stage-1 time of N, the bark occurs on the N-th tick after the start. At the bark, `irq` goes high and bit 6 of offset 0x10 reads 1.
- R5: With a stage-2 time of M, the reset request follows M ticks after the bark. With M = 0, the request comes on the same tick as the bark.
- R6: `rst_req` is high for exactly one cycle and carries the low 3 bits of 0x56 (0x01 warm, 0x04 shutdown, 0x07 hard). After the request the count holds: no further request comes until a kick or a fresh arming.
- R7: Writing 0x58 with bit 0 set while armed restarts stage 1 and clears the bark, including during stage 2. A write with bit 0 clear, or a kick while disarmed, has no effect.
- R8: A timer register written while the watchdog runs does not change the current count. The new value is used from the next kick or arming onward.
- R9: A reset request sets bit 2 of 0x0C. A `uv_evt` pulse sets bit 5 of 0x0D. An `ot_evt` pulse sets bit 6 of 0x0D. These flags survive `rst_n` and are cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset, the one the reset request drives |
| por_n | input | 1 | Active-low power-on reset that clears the cause flags |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| uv_evt | input | 1 | Undervoltage event pulse |
| ot_evt | input | 1 | Over-temperature event pulse |
| irq | output | 1 | Bark interrupt, a level |
| rst_req | output | 3 | Reset-type code, valid for one cycle, 0 otherwise |

## Verification
A wrong stage or count value shows at the ports on the very next tick. The bark then rises a tick early or late, or the reset code comes out at the wrong moment or twice, so the bench compares `irq` and every `rst_req` pulse after each tick. A stale latched stage-2 length or timer value shows only after the next bark, which is why the bench rewrites the timers in mid-run and then lets the watchdog expire. A corrupted cause flag is invisible until software reads 0x0C or 0x0D, so those reads are taken both after the block reset and after the power-on reset.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int TW       = 7,
  parameter int DEF_S1   = 32,
  parameter int DEF_S2   = 0,
  parameter int DEF_TYPE = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       uv_evt,
  input  logic       ot_evt,
  output logic       irq,
  output logic [2:0] rst_req
);
  localparam logic [7:0] A_CAUSE1 = 8'h0c;
  localparam logic [7:0] A_CAUSE2 = 8'h0d;
  localparam logic [7:0] A_STAT   = 8'h10;
  localparam logic [7:0] A_T1     = 8'h54;
  localparam logic [7:0] A_T2     = 8'h55;
  localparam logic [7:0] A_TYPE   = 8'h56;
  localparam logic [7:0] A_ARM    = 8'h57;
  localparam logic [7:0] A_KICK   = 8'h58;

  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO, ST_HOLD} stage_t;

  stage_t        stage;
  logic [TW-1:0] t1_r, t2_r, t2_lat, cnt;
  logic [2:0]    type_r;
  logic          en, bark;
  logic          wd_flag, uv_flag, ot_flag;

  wire arm_wr  = wr_en && addr == A_ARM;
  wire kick    = wr_en && addr == A_KICK && wdata[0] && en;
  wire restart = (arm_wr && wdata[7] && !en) || kick;
  wire stop    = arm_wr && !wdata[7];
  wire step    = sec_tick && !restart && !stop && (stage == ST_ONE || stage == ST_TWO);
  wire expire  = cnt <= TW'(1);
  wire bark_now = step && stage == ST_ONE && expire;
  wire fire    = step && expire && (stage == ST_TWO || t2_lat == '0);

  assign irq = bark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_r    <= TW'(DEF_S1);
      t2_r    <= TW'(DEF_S2);
      type_r  <= 3'(DEF_TYPE);
      en      <= 1'b0;
      stage   <= ST_IDLE;
      cnt     <= '0;
      t2_lat  <= '0;
      bark    <= 1'b0;
      rst_req <= '0;
    end else begin
      rst_req <= '0;
      if (wr_en && addr == A_T1)   t1_r   <= wdata[TW-1:0];
      if (wr_en && addr == A_T2)   t2_r   <= wdata[TW-1:0];
      if (wr_en && addr == A_TYPE) type_r <= wdata[2:0];
      if (arm_wr) en <= wdata[7];
      if (restart) begin
        stage  <= ST_ONE;
        cnt    <= t1_r;
        t2_lat <= t2_r;
        bark   <= 1'b0;
      end else if (stop) begin
        stage <= ST_IDLE;
        bark  <= 1'b0;
      end else if (step) begin
        if (fire) begin
          stage   <= ST_HOLD;
          rst_req <= type_r;
        end else if (bark_now) begin
          stage <= ST_TWO;
          cnt   <= t2_lat;
        end else begin
          cnt <= cnt - TW'(1);
        end
        if (bark_now) bark <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_flag <= 1'b0;
      uv_flag <= 1'b0;
      ot_flag <= 1'b0;
    end else begin
      wd_flag <= wd_flag | fire;
      uv_flag <= uv_flag | uv_evt;
      ot_flag <= ot_flag | ot_evt;
    end
  end

  always_comb begin
    case (addr)
      A_CAUSE1: rdata = {5'b0, wd_flag, 2'b0};
      A_CAUSE2: rdata = {1'b0, ot_flag, uv_flag, 5'b0};
      A_STAT:   rdata = {1'b0, bark, 6'b0};
      A_T1:     rdata = 8'(t1_r);
      A_T2:     rdata = 8'(t2_r);
      A_TYPE:   rdata = {5'b0, type_r};
      A_ARM:    rdata = {en, 7'b0};
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       irq,
  input logic [2:0] rst_req,
  input logic       en,
  input logic       wd_flag
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req != 3'd0 |=> rst_req == 3'd0); // R6

  AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req != 3'd0 |-> $past(sec_tick)); // R5

  AST_BARK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sec_tick)); // R4

  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> rst_req == 3'd0); // R3

  AST_CAUSE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req != 3'd0 |-> wd_flag); // R9
endmodule

bind wdog_two_stage wdog_two_stage_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .irq(irq),
  .rst_req(rst_req), .en(en), .wd_flag(wd_flag)
);

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, por_n = 1'b0;
  logic       sec_tick = 1'b0, wr_en = 1'b0, uv_evt = 1'b0, ot_evt = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic       irq;
  logic [2:0] rst_req;

  int errors = 0, checks = 0;
  int pulses = 0;
  int last_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sec_tick(sec_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .uv_evt(uv_evt), .ot_evt(ot_evt), .irq(irq), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    #1;
    if (rst_req != 3'd0) begin
      pulses++;
      last_code = int'(rst_req);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    int v, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (2) @(negedge clk);

    rd(8'h54, v); chk("R1 t1 default", v, 32);
    rd(8'h55, v); chk("R1 t2 default", v, 0);
    rd(8'h56, v); chk("R1 type default", v, 7);
    rd(8'h57, v); chk("R1 arm default", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst_req", int'(rst_req), 0);

    // R2: unmapped offsets, kick reads 0, 7-bit timers
    rd(8'h00, v); chk("R2 unmapped 00", v, 0);
    rd(8'h11, v); chk("R2 unmapped 11", v, 0);
    rd(8'h58, v); chk("R2 kick reads 0", v, 0);
    rd(8'hff, v); chk("R2 unmapped ff", v, 0);
    wr(8'h54, 8'hff); rd(8'h54, v); chk("R2 t1 7 bits", v, 127);
    wr(8'h55, 8'hc3); rd(8'h55, v); chk("R2 t2 7 bits", v, 67);

    // R5 defaults: 32 s then bark and hard reset together
    wr(8'h54, 8'd32); wr(8'h55, 8'd0);
    p0 = pulses;
    wr(8'h57, 8'h80);
    rd(8'h57, v); chk("R3 arm reads running", v, 128);
    ticks(31);
    chk("R4 no bark before 32", int'(irq), 0);
    tick();
    chk("R4 bark at 32", int'(irq), 1);
    rd(8'h10, v); chk("R4 status bit6", v, 64);
    chk("R5 same-tick reset", pulses - p0, 1);
    chk("R6 hard code", last_code, 7);
    rd(8'h0c, v); chk("R9 watchdog cause", v, 4);
    ticks(5);
    chk("R6 hold after fire", pulses - p0, 1);

    // Sweep over stage lengths and reset types
    for (int a = 1; a <= 5; a++) begin
      for (int b = 0; b <= 3; b++) begin
        int code, fired;
        code = (b == 0) ? 1 : (b == 1 ? 4 : 7);
        wr(8'h57, 8'h00);
        wr(8'h54, 8'(a)); wr(8'h55, 8'(b)); wr(8'h56, 8'(code));
        p0 = pulses;
        wr(8'h57, 8'h80);
        for (int k = 1; k <= a + b + 2; k++) begin
          tick();
          fired = (k >= a + b) ? 1 : 0;
          chk("R4 sweep irq", int'(irq), (k >= a) ? 1 : 0);
          chk("R5 sweep pulse count", pulses - p0, fired);
        end
        chk("R6 sweep code", last_code, code);
      end
    end

    // R3: re-arm while armed does not restart; disarm stops all
    wr(8'h57, 8'h00);
    wr(8'h54, 8'd3); wr(8'h55, 8'd2);
    wr(8'h57, 8'h80);
    ticks(2);
    wr(8'h57, 8'h80);
    tick();
    chk("R3 rearm no restart", int'(irq), 1);
    wr(8'h57, 8'h00);
    chk("R3 disarm clears irq", int'(irq), 0);
    rd(8'h57, v); chk("R3 arm reads stopped", v, 0);
    p0 = pulses;
    ticks(8);
    chk("R3 disarmed no bark", int'(irq), 0);
    chk("R3 disarmed no reset", pulses - p0, 0);

    // R7: kicks
    wr(8'h58, 8'h01);
    wr(8'h57, 8'h80);
    ticks(2);
    wr(8'h58, 8'h01);
    ticks(2);
    chk("R7 kick restarts", int'(irq), 0);
    wr(8'h58, 8'hfe);
    tick();
    chk("R7 bit0 clear ignored", int'(irq), 1);
    p0 = pulses;
    wr(8'h58, 8'h01);
    chk("R7 kick clears bark", int'(irq), 0);
    ticks(4);
    chk("R7 stage2 kick no reset", pulses - p0, 0);
    chk("R7 rebark", int'(irq), 1);

    // R8: timer change used at next kick
    wr(8'h58, 8'h01);
    wr(8'h54, 8'd6);
    ticks(3);
    chk("R8 old t1 still used", int'(irq), 1);
    wr(8'h58, 8'h01);
    ticks(5);
    chk("R8 new t1 not yet", int'(irq), 0);
    tick();
    chk("R8 new t1 at kick", int'(irq), 1);

    // R9: event flags, sticky across rst_n, cleared by por_n
    @(negedge clk); uv_evt = 1'b1; @(negedge clk); uv_evt = 1'b0;
    rd(8'h0d, v); chk("R9 undervoltage", v, 32);
    @(negedge clk); ot_evt = 1'b1; @(negedge clk); ot_evt = 1'b0;
    rd(8'h0d, v); chk("R9 overtemp", v, 96);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(8'h0c, v); chk("R9 wd flag kept", v, 4);
    rd(8'h0d, v); chk("R9 env flags kept", v, 96);
    rd(8'h54, v); chk("R1 t1 after reset", v, 32);
    chk("R1 irq after reset", int'(irq), 0);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    rd(8'h0c, v); chk("R9 por clears wd", v, 0);
    rd(8'h0d, v); chk("R9 por clears env", v, 0);

    summary();
  end
endmodule